// File: doc/BRIEF.md
# Ratiometric Differential-Transformer Position Tracker

The block turns two signed, already demodulated amplitude samples, one from each secondary winding of a differential position transformer, into a tracked 16-bit position word. The word represents the ratio (A−B)/(A+B). Because the result is a ratio, a change in overall excitation amplitude leaves it unchanged. The block also produces a scaled, signed 16-bit velocity word.

A second-order (Type II) loop does the tracking. The loop error is formed by cross-multiplication, (A−B)·2^15 − pos·(A+B), so no divider is needed. The error is then shifted right by the bit index of the most significant one in A+B, which keeps the loop gain within a factor of two over the whole amplitude range. The error feeds a velocity integrator, and the velocity integrator feeds a position integrator that carries 8 fractional bits. Both integrators saturate instead of wrapping.

When A+B falls below a minimum, the sample is rejected: the loop state holds and a signal-loss flag rises. The position word is presented either in two's complement or in offset binary. The velocity word is scaled by a 16-bit factor.

Top module: `lvdt_ratio_tracker`

## Requirements
- R1: After reset, the position state and the velocity state are zero and the loss flag is 0. `pos_word` reads 0x0000 in two's complement and 0x8000 in offset binary, and `vel_word` reads 0.
- R2: For constant valid samples with A+B ≥ MIN_SUM (default 64), `pos_word` lies within ±2 LSB of round(32768·(A−B)/(A+B)) within 300 samples from any prior state. It stays inside that band, with no sustained oscillation, over samples 260 to 299.
- R3: Scaling A and B by a common factor (sums from 160 to 30000) gives the same settled position within ±4 LSB.
- R4: A ratio of +1 or above gives exactly 0x7FFF. A ratio below −1 gives exactly 0x8000. The position integrator saturates and does not wrap.
- R5: In two's complement, bit 15 of `pos_word` is 1 when A<B and 0 when A>B.
- R6: With `offset_fmt`=1, `pos_word` equals the two's-complement word with bit 15 inverted. The change appears combinationally, in the same cycle.
- R7: A valid sample whose signed sum A+B is below MIN_SUM sets `sig_loss` at the next clock edge and leaves position and velocity unchanged. A valid sample with A+B ≥ MIN_SUM clears `sig_loss` at the next edge; the boundary value A+B = 64 counts as good.
- R8: While `smp_valid`=0, `pos_word`, `vel_word` and `sig_loss` do not change.
- R9: For a ramp input moving 2 LSB per sample, the tracked position follows with no steady-state lag: it stays within ±4 LSB of the latest target after 1000 samples.
- R10: The internal velocity V is expressed in units of 1/256 position LSB per sample. `vel_word` = floor(V·scale/65536), in two's complement. With scale 0xFFFF, a ramp of +2 LSB/sample reads about +511 and a ramp of −2 LSB/sample reads about −512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Qualifies samp_a / samp_b for one cycle |
| samp_a | input | 16 | Signed amplitude of secondary A |
| samp_b | input | 16 | Signed amplitude of secondary B |
| offset_fmt | input | 1 | 1 = offset binary position output, 0 = two's complement |
| vel_scale | input | 16 | Unsigned velocity scale factor, 0xFFFF ≈ unity |
| pos_word | output | 16 | Tracked position word |
| vel_word | output | 16 | Scaled signed velocity word |
| sig_loss | output | 1 | Last valid sample had A+B below the minimum |

## Verification
A corrupted velocity integrator shows at the ports within one sample. A corrupted position integrator also shows at once, and both keep showing as a settling error or as residual oscillation that outlasts the 300-sample window. Sweeping the ratio over fifteen points at three amplitudes exposes gain-normalisation mistakes, because a wrong shift makes the small-amplitude runs overshoot or crawl. A wrong sign in the cross-multiply makes the loop diverge to a rail within a few samples. A ramp exposes a missing integrator as a steady lag, and a frozen-state scale sweep isolates the velocity multiplier from the loop.

// File: rtl/lvdt_trk_pkg.sv
package lvdt_trk_pkg;

    // Flag register of the top level
    typedef struct packed {
        logic loss;
    } flag_st_t;

    // Bit index of the most significant one, 0 for a zero input
    function automatic int msb_idx(input logic [63:0] v);
        int res;
        res = 0;
        for (int i = 0; i < 64; i++) begin
            if (v[i]) res = i;
        end
        return res;
    endfunction

    // Clamp a wide signed value into a w-bit signed range
    function automatic logic signed [63:0] sat_s(input logic signed [63:0] x, input int w);
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -hi - 64'sd1;
        if (x > hi)      return hi;
        else if (x < lo) return lo;
        else             return x;
    endfunction

endpackage

// File: rtl/trk_ratio_error.sv
module trk_ratio_error #(
    parameter  int SAMPLE_W = 16,
    parameter  int POS_W    = 16,
    parameter  int MIN_SUM  = 64,
    localparam int ERR_W    = SAMPLE_W + POS_W + 2
) (
    input  logic signed [SAMPLE_W-1:0] a_i,
    input  logic signed [SAMPLE_W-1:0] b_i,
    input  logic signed [POS_W-1:0]    pos_i,
    output logic signed [ERR_W-1:0]    err_o,
    output logic                       low_o
);
    import lvdt_trk_pkg::*;

    localparam int SUM_W = SAMPLE_W + 1;

    logic signed [SUM_W-1:0] diff_w;
    logic signed [SUM_W-1:0] sum_w;
    logic signed [ERR_W-1:0] num_w;
    logic signed [ERR_W-1:0] prod_w;
    logic signed [ERR_W-1:0] raw_w;
    int                      norm_k;

    always_comb begin
        diff_w = $signed({a_i[SAMPLE_W-1], a_i}) - $signed({b_i[SAMPLE_W-1], b_i});
        sum_w  = $signed({a_i[SAMPLE_W-1], a_i}) + $signed({b_i[SAMPLE_W-1], b_i});
        // ratio target scaled by 2^(POS_W-1) minus estimate times sum
        num_w  = ERR_W'(diff_w) <<< (POS_W - 1);
        prod_w = ERR_W'(pos_i) * ERR_W'(sum_w);
        raw_w  = num_w - prod_w;
        low_o  = (sum_w < $signed(SUM_W'(MIN_SUM)));
        // normalise by the magnitude of the sum so loop gain stays in [1,2)
        norm_k = msb_idx(64'(sum_w[SAMPLE_W-1:0]));
        err_o  = raw_w >>> norm_k;
    end

endmodule

// File: rtl/trk_loop.sv
module trk_loop #(
    parameter int POS_W  = 16,
    parameter int FRAC_W = 8,
    parameter int VEL_W  = 16,
    parameter int KP_SH  = 2,
    parameter int KI_SH  = 5,
    parameter int ERR_W  = 34
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic signed [POS_W-1:0] pos_o,
    output logic signed [VEL_W-1:0] vel_o
);
    import lvdt_trk_pkg::*;

    localparam int ACC_W = POS_W + FRAC_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] pos;
        logic signed [VEL_W-1:0] vel;
    } loop_st_t;

    loop_st_t st_d, st_q;

    logic signed [63:0] e_scl;
    logic signed [63:0] v_sum;
    logic signed [63:0] v_sat;
    logic signed [63:0] p_sum;

    always_comb begin
        st_d  = st_q;
        e_scl = 64'(err_i) <<< FRAC_W;
        // velocity integrator: integral path
        v_sum = 64'(st_q.vel) + (e_scl >>> KI_SH);
        v_sat = sat_s(v_sum, VEL_W);
        // position integrator: fed by velocity plus proportional path
        p_sum = 64'(st_q.pos) + v_sat + (e_scl >>> KP_SH);
        if (upd_i) begin
            st_d.vel = VEL_W'(v_sat);
            st_d.pos = ACC_W'(sat_s(p_sum, ACC_W));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_o = st_q.pos[ACC_W-1:FRAC_W];
    assign vel_o = st_q.vel;

endmodule

// File: rtl/trk_out_format.sv
module trk_out_format #(
    parameter int POS_W   = 16,
    parameter int VEL_W   = 16,
    parameter int SCALE_W = 16
) (
    input  logic signed [POS_W-1:0] pos_i,
    input  logic signed [VEL_W-1:0] vel_i,
    input  logic                    offset_i,
    input  logic [SCALE_W-1:0]      scale_i,
    output logic [POS_W-1:0]        pos_word_o,
    output logic [VEL_W-1:0]        vel_word_o
);
    logic signed [63:0] v_prod;

    always_comb begin
        if (offset_i) pos_word_o = {~pos_i[POS_W-1], pos_i[POS_W-2:0]};
        else          pos_word_o = pos_i;
        v_prod     = 64'(vel_i) * 64'($signed({1'b0, scale_i}));
        vel_word_o = VEL_W'(v_prod >>> SCALE_W);
    end

endmodule

// File: rtl/lvdt_ratio_tracker.sv
module lvdt_ratio_tracker #(
    parameter int SAMPLE_W = 16,
    parameter int POS_W    = 16,
    parameter int FRAC_W   = 8,
    parameter int VEL_W    = 16,
    parameter int SCALE_W  = 16,
    parameter int KP_SH    = 2,
    parameter int KI_SH    = 5,
    parameter int MIN_SUM  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] samp_a,
    input  logic signed [SAMPLE_W-1:0] samp_b,
    input  logic                       offset_fmt,
    input  logic [SCALE_W-1:0]         vel_scale,
    output logic [POS_W-1:0]           pos_word,
    output logic [VEL_W-1:0]           vel_word,
    output logic                       sig_loss
);
    import lvdt_trk_pkg::*;

    localparam int ERR_W = SAMPLE_W + POS_W + 2;

    logic signed [ERR_W-1:0] err_w;
    logic                    low_w;
    logic signed [POS_W-1:0] pos_w;
    logic signed [VEL_W-1:0] vel_w;
    flag_st_t                fl_d, fl_q;

    trk_ratio_error #(
        .SAMPLE_W(SAMPLE_W), .POS_W(POS_W), .MIN_SUM(MIN_SUM)
    ) i_err (
        .a_i(samp_a), .b_i(samp_b), .pos_i(pos_w), .err_o(err_w), .low_o(low_w)
    );

    trk_loop #(
        .POS_W(POS_W), .FRAC_W(FRAC_W), .VEL_W(VEL_W),
        .KP_SH(KP_SH), .KI_SH(KI_SH), .ERR_W(ERR_W)
    ) i_loop (
        .clk(clk), .rst_n(rst_n), .upd_i(smp_valid && !low_w),
        .err_i(err_w), .pos_o(pos_w), .vel_o(vel_w)
    );

    trk_out_format #(
        .POS_W(POS_W), .VEL_W(VEL_W), .SCALE_W(SCALE_W)
    ) i_fmt (
        .pos_i(pos_w), .vel_i(vel_w), .offset_i(offset_fmt), .scale_i(vel_scale),
        .pos_word_o(pos_word), .vel_word_o(vel_word)
    );

    always_comb begin
        fl_d = fl_q;
        if (smp_valid) fl_d.loss = low_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign sig_loss = fl_q.loss;

endmodule

// File: rtl/lvdt_trk_checks.sv
module lvdt_trk_checks #(
    parameter int SAMPLE_W = 16,
    parameter int POS_W    = 16,
    parameter int VEL_W    = 16,
    parameter int SCALE_W  = 16,
    parameter int MIN_SUM  = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       smp_valid,
    input logic signed [SAMPLE_W-1:0] samp_a,
    input logic signed [SAMPLE_W-1:0] samp_b,
    input logic                       offset_fmt,
    input logic [SCALE_W-1:0]         vel_scale,
    input logic [POS_W-1:0]           pos_word,
    input logic [VEL_W-1:0]           vel_word,
    input logic                       sig_loss
);
    logic signed [SAMPLE_W:0] chk_sum;
    logic                     chk_low;

    assign chk_sum = $signed({samp_a[SAMPLE_W-1], samp_a}) + $signed({samp_b[SAMPLE_W-1], samp_b});
    assign chk_low = chk_sum < $signed((SAMPLE_W + 1)'(MIN_SUM));

    a_r7_loss_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && chk_low) |=> sig_loss);

    a_r7_loss_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !chk_low) |=> !sig_loss);

    a_r7_pos_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && chk_low) |=> (!$stable(offset_fmt) || $stable(pos_word)));

    a_r8_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(sig_loss) && (!$stable(offset_fmt) || $stable(pos_word))));

    a_r8_vel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid || chk_low) |=> (!$stable(vel_scale) || $stable(vel_word)));

endmodule

bind lvdt_ratio_tracker lvdt_trk_checks #(
    .SAMPLE_W(SAMPLE_W), .POS_W(POS_W), .VEL_W(VEL_W), .SCALE_W(SCALE_W), .MIN_SUM(MIN_SUM)
) i_checks (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .samp_a(samp_a), .samp_b(samp_b),
    .offset_fmt(offset_fmt), .vel_scale(vel_scale), .pos_word(pos_word),
    .vel_word(vel_word), .sig_loss(sig_loss)
);

// File: tb/test_lvdt_ratio_tracker.sv
module test_lvdt_ratio_tracker;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid = 1'b0;
    logic signed [15:0] samp_a = '0;
    logic signed [15:0] samp_b = '0;
    logic               offset_fmt = 1'b0;
    logic [15:0]        vel_scale = 16'hFFFF;
    logic [15:0]        pos_word;
    logic [15:0]        vel_word;
    logic               sig_loss;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lvdt_ratio_tracker i_lvdt_ratio_tracker (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .samp_a(samp_a), .samp_b(samp_b),
        .offset_fmt(offset_fmt), .vel_scale(vel_scale), .pos_word(pos_word),
        .vel_word(vel_word), .sig_loss(sig_loss)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // inputs applied at a falling edge; returns at the next falling edge
    task automatic drive(input int a, input int b, input bit v);
        samp_a    = 16'(a);
        samp_b    = 16'(b);
        smp_valid = v;
        @(negedge clk);
    endtask

    function automatic int pos_i();
        return int'($signed(pos_word));
    endfunction

    function automatic int vel_i();
        return int'($signed(vel_word));
    endfunction

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    function automatic int exp_ratio(input int a, input int b);
        longint num, den, q;
        num = longint'(a - b) * 32768;
        den = longint'(a + b);
        if (num >= 0) q = (num + den / 2) / den;
        else          q = -((-num + den / 2) / den);
        if (q > 32767)  q = 32767;
        if (q < -32768) q = -32768;
        return int'(q);
    endfunction

    task automatic settle(input int a, input int b, output int p_end, output int maxdev);
        int e;
        e = exp_ratio(a, b);
        maxdev = 0;
        for (int n = 0; n < 300; n++) begin
            drive(a, b, 1'b1);
            if (n >= 260 && iabs(pos_i() - e) > maxdev) maxdev = iabs(pos_i() - e);
        end
        p_end = pos_i();
    endtask

    int amps[3] = '{160, 2000, 30000};
    int res[3][15];

    initial begin
        int pe, md, pw, vw, lw, v1, exp_v, x, md2;
        bit frozen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(pos_word == 16'h0000, "R1 pos after reset", pos_i(), 0);
        check(vel_word == 16'h0000, "R1 vel after reset", vel_i(), 0);
        check(sig_loss == 1'b0, "R1 loss after reset", int'(sig_loss), 0);
        offset_fmt = 1'b1; #1;
        check(pos_word == 16'h8000, "R1 offset reset word", int'(pos_word), 32768);
        offset_fmt = 1'b0;

        // R2/R3/R5/R6 ratio sweep at three amplitudes
        for (int s = 0; s < 3; s++) begin
            for (int i = -7; i <= 7; i++) begin
                int a, b;
                a = (amps[s] * (8 + i)) / 16;
                b = amps[s] - a;
                settle(a, b, pe, md);
                res[s][i + 7] = pe;
                check(md <= 2, "R2 settle band", pe, exp_ratio(a, b));
                if (i < 0) check(pos_word[15] == 1'b1, "R5 sign for A<B", int'(pos_word[15]), 1);
                if (i > 0) check(pos_word[15] == 1'b0, "R5 sign for A>B", int'(pos_word[15]), 0);
                pw = int'(pos_word);
                offset_fmt = 1'b1; #1;
                check(int'(pos_word) == (pw ^ 32'h8000), "R6 offset binary", int'(pos_word), pw ^ 32'h8000);
                offset_fmt = 1'b0;
            end
        end
        for (int i = 0; i < 15; i++) begin
            check(iabs(res[2][i] - res[0][i]) <= 4, "R3 amplitude invariance", res[0][i], res[2][i]);
            check(iabs(res[1][i] - res[2][i]) <= 4, "R3 amplitude invariance", res[1][i], res[2][i]);
        end

        // R4 saturation
        settle(1000, 0, pe, md);
        check(pos_word == 16'h7FFF, "R4 ratio +1", pos_i(), 32767);
        settle(1000, -200, pe, md);
        check(pos_word == 16'h7FFF, "R4 ratio above +1", pos_i(), 32767);
        settle(-300, 1200, pe, md);
        check(pos_word == 16'h8000, "R4 ratio below -1", pos_i(), -32768);
        settle(0, 1000, pe, md);
        check(iabs(pos_i() + 32768) <= 2, "R4 ratio -1", pos_i(), -32768);

        // R7 signal loss
        settle(1500, 500, pe, md);
        pw = int'(pos_word); vw = int'(vel_word);
        drive(40, 23, 1'b1);
        check(sig_loss == 1'b1, "R7 loss raised sum 63", int'(sig_loss), 1);
        check(int'(pos_word) == pw, "R7 pos held on loss", int'(pos_word), pw);
        drive(-100, 50, 1'b1);
        check(sig_loss == 1'b1, "R7 loss on negative sum", int'(sig_loss), 1);
        check(int'(pos_word) == pw, "R7 pos held on negative sum", int'(pos_word), pw);
        check(int'(vel_word) == vw, "R7 vel held on loss", int'(vel_word), vw);
        drive(32, 32, 1'b1);
        check(sig_loss == 1'b0, "R7 loss cleared at sum 64", int'(sig_loss), 0);

        // R8 idle hold
        settle(1500, 500, pe, md);
        drive(1500, 500, 1'b0);
        pw = int'(pos_word); vw = int'(vel_word); lw = int'(sig_loss);
        frozen = 1'b1;
        for (int n = 0; n < 20; n++) begin
            drive(-7000, 100, 1'b0);
            if (int'(pos_word) != pw || int'(vel_word) != vw || int'(sig_loss) != lw) frozen = 1'b0;
        end
        check(frozen, "R8 idle hold", int'(pos_word), pw);

        // R9/R10 ascending ramp, 2 LSB per sample
        md = 0; md2 = 0;
        for (int n = 0; n < 3000; n++) begin
            x = -8000 + n;
            drive(16384 + x, 16384 - x, 1'b1);
            if (n >= 1000) begin
                if (iabs(pos_i() - 2 * x) > md) md = iabs(pos_i() - 2 * x);
                if (iabs(vel_i() - 511) > md2) md2 = iabs(vel_i() - 511);
            end
        end
        check(md <= 4, "R9 ramp up lag", md, 0);
        check(md2 <= 8, "R10 ramp up velocity", vel_i(), 511);

        // R10 scale sweep on frozen state
        smp_valid = 1'b0;
        vel_scale = 16'hFFFF;
        drive(0, 0, 1'b0);
        v1 = vel_i();
        for (int s = 0; s < 65536; s += 257) begin
            vel_scale = 16'(s);
            drive(0, 0, 1'b0);
            exp_v = (v1 * s) >>> 16;
            check(iabs(vel_i() - exp_v) <= 1, "R10 scale sweep", vel_i(), exp_v);
        end
        vel_scale = 16'h0000;
        drive(0, 0, 1'b0);
        check(vel_word == 16'h0000, "R10 zero scale", vel_i(), 0);
        vel_scale = 16'hFFFF;

        // R9/R10 descending ramp
        md = 0; md2 = 0;
        for (int n = 0; n < 3000; n++) begin
            x = -5000 - n;
            drive(16384 + x, 16384 - x, 1'b1);
            if (n >= 1000) begin
                if (iabs(pos_i() - 2 * x) > md) md = iabs(pos_i() - 2 * x);
                if (iabs(vel_i() + 512) > md2) md2 = iabs(vel_i() + 512);
            end
        end
        check(md <= 4, "R9 ramp down lag", md, 0);
        check(md2 <= 8, "R10 ramp down velocity", vel_i(), -512);
        smp_valid = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule